// File: doc/BRIEF.md
# Configuration Register Loader over I2C

This block is a target on a two-wire I2C bus. It fills a bank of seven 8-bit configuration registers from block writes and lets the bus master read the whole bank back for verification. SCL and SDA come in as plain logic levels. A synchronizer samples them on the system clock, so SCL runs many times slower than `clk`. The block answers by pulling SDA low through `sda_pull`. The board supplies the open-drain pad and the pull-up.

A write opens with the write address byte. Two more bytes follow, a command byte and a count byte. Both are acknowledged and then thrown away. Every byte after them lands in the next register, starting at register 0, until the master sends STOP. A read opens with the read address byte. The target then sends register 0, 1, 2 and so on, until the master answers a byte with NACK. While `pwr_dn` is high the bus is not watched at all, and the registers keep their contents. Register 0 is also decoded into named control fields for the clock logic around the block.

The controller has seven states:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts in the address byte. On the falling SCL edge after bit 8 it goes to `ST_ADDR_ACK` if the address matches, and back to `ST_IDLE` if it does not.
- `ST_ADDR_ACK` holds SDA low for one SCL period. It then goes to `ST_RD_BYTE` when the R/W bit is 1, or to `ST_WR_BYTE` when it is 0.
- `ST_WR_BYTE` shifts in a data byte and commits it on the falling edge after bit 8. It then goes to `ST_WR_ACK`.
- `ST_WR_ACK` drives the acknowledge and returns to `ST_WR_BYTE`.
- `ST_RD_BYTE` sends eight bits, MSB first, and moves to `ST_RD_ACK`.
- `ST_RD_ACK` samples the master's answer on the rising SCL edge. NACK goes to `ST_IDLE`. ACK reloads the next register at the falling edge and returns to `ST_RD_BYTE`.

Three events override every state. START goes to `ST_ADDR`. STOP goes to `ST_IDLE`. Power-down goes to `ST_IDLE`.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x00 and registers 1 to 6 hold 0xFF, and SDA is not pulled.
- R2: The block acknowledges the address byte 0xD2 (write) and 0xD3 (read), and it acknowledges every following write byte. Any other address byte gets no acknowledge. SDA changes only while SCL is low.
- R3: In a write, the first two bytes after the address are acknowledged and change no register.
- R4: In a write, the third byte after the address goes to register 0, the fourth to register 1, and so on. After a STOP that follows any complete byte, every byte already received keeps its new value. At most one register changes per clock cycle.
- R5: A byte cut short by STOP before all 8 bits arrive changes no register.
- R6: Data bytes beyond register 6 are acknowledged and change no register.
- R7: A read returns register 0 first, then the following registers in order, MSB first, with no count byte in front. Positions past register 6 read 0xFF.
- R8: When the master answers a read byte with NACK, the block releases SDA and drives no further bits until the next START.
- R9: While `pwr_dn` is high, the block ignores SCL and SDA, never pulls SDA, and keeps every register unchanged. Values written before power-down survive it.
- R10: Register 0 is decoded into these fields:
  - bit 7: `ss_narrow`
  - bits 6:4: `freq_code`
  - bit 3: `freq_from_reg`
  - bit 2: `ss_down`
  - bit 1: `ss_on`
  - bit 0: `hiz_all`
- R11: Register 6 has no control function, and it reads back exactly the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND with the block's pull) |
| pwr_dn | input | 1 | Power-down: bus ignored, registers held |
| sda_pull | output | 1 | 1 pulls SDA low |
| regs_o | output | 56 | Register bank, register n at bits [8n+7:8n] |
| ss_narrow | output | 1 | Register 0 bit 7, spread-amount select |
| freq_code | output | 3 | Register 0 bits 6:4, frequency code |
| freq_from_reg | output | 1 | Register 0 bit 3, frequency taken from the register rather than strap pins |
| ss_down | output | 1 | Register 0 bit 2, down-spread rather than center-spread |
| ss_on | output | 1 | Register 0 bit 1, spread enable |
| hiz_all | output | 1 | Register 0 bit 0, tristate all outputs |

## Verification
The assertions check four things on every cycle:
- SDA is only driven or released while the synchronized SCL is low.
- Power-down neither pulls SDA nor changes any register.
- No more than one register changes per cycle.
- The bank comes out of reset with its default contents.

Some behaviour only the bench scenarios can show: which register a given byte lands in, that the two leading bytes are discarded, that a truncated byte or an overflow byte is dropped, the order of bytes read back, and SDA being released after NACK.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic mask,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [SYNC_N-1:0] scl_sh, sda_sh;
    logic              scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC_N-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC_N-2:0], sda_i};
            scl_prev <= scl_sh[SYNC_N-1];
            sda_prev <= sda_sh[SYNC_N-1];
        end
    end

    assign scl_lvl  = scl_sh[SYNC_N-1];
    assign sda_lvl  = sda_sh[SYNC_N-1];
    assign ev_rise  = !mask && scl_lvl && !scl_prev;
    assign ev_fall  = !mask && !scl_lvl && scl_prev;
    assign ev_start = !mask && scl_lvl && scl_prev && sda_prev && !sda_lvl;
    assign ev_stop  = !mask && scl_lvl && scl_prev && !sda_prev && sda_lvl;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int NREGS = 7,
    parameter int DW    = 8,
    localparam int IDX_W = $clog2(NREGS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DW-1:0]       rd_data,
    output logic [NREGS*DW-1:0] regs_flat
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [DW-1:0] RST_VAL = (g == 0) ? '0 : '1;
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= RST_VAL;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_data;
        end
        assign regs_flat[g*DW +: DW] = q;
    end

    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NREGS; i++)
            if (rd_idx == IDX_W'(i)) rd_data = regs_flat[i*DW +: DW];
    end
endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfgi2c_pkg::*;
#(
    parameter int          NREGS = 7,
    parameter int          DW    = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    localparam int IDX_W = $clog2(NREGS + 1),
    localparam int BN_W  = $clog2(NREGS + 3) + 1,
    localparam int BC_W  = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             sda_lvl,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic [DW-1:0]    rd_data,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [DW-1:0]    wr_data,
    output logic [IDX_W-1:0] rd_idx
);
    bus_state_e       state, nxt;
    logic [BC_W-1:0]  bit_cnt;
    logic [BN_W-1:0]  byte_no;
    logic [DW-1:0]    rx_sh, tx_sh;
    logic             rw_q;
    logic             byte_end;

    assign byte_end = ev_fall && (bit_cnt == BC_W'(DW));

    // next state
    always_comb begin
        nxt = state;
        if (pwr_dn)        nxt = ST_IDLE;
        else if (ev_start) nxt = ST_ADDR;
        else if (ev_stop)  nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 nxt = (rx_sh[DW-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (ev_fall) nxt = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (ev_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (ev_rise && sda_lvl) nxt = ST_IDLE;
                             else if (ev_fall) nxt = ST_RD_BYTE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            byte_no <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            rw_q    <= 1'b0;
            rd_idx  <= '0;
        end else if (pwr_dn || ev_start) begin
            bit_cnt <= '0;
            byte_no <= '0;
            rd_idx  <= '0;
            tx_sh   <= '1;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (ev_rise) begin
                        rx_sh   <= {rx_sh[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_end && state == ST_ADDR) rw_q <= rx_sh[0];
                    if (byte_end && state == ST_WR_BYTE && byte_no != '1)
                        byte_no <= byte_no + 1'b1;
                end
                ST_ADDR_ACK: if (ev_fall) begin
                    bit_cnt <= '0;
                    tx_sh   <= rd_data;
                end
                ST_WR_ACK: if (ev_fall) bit_cnt <= '0;
                ST_RD_BYTE: begin
                    if (ev_rise) bit_cnt <= bit_cnt + 1'b1;
                    if (byte_end) begin
                        tx_sh <= '1;
                        if (rd_idx != IDX_W'(NREGS)) rd_idx <= rd_idx + 1'b1;
                    end else if (ev_fall) begin
                        tx_sh <= {tx_sh[DW-2:0], 1'b1};
                    end
                end
                ST_RD_ACK: if (ev_fall) begin
                    bit_cnt <= '0;
                    tx_sh   <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_BYTE:             sda_pull = !tx_sh[DW-1];
            default:                sda_pull = 1'b0;
        endcase
        wr_en   = (state == ST_WR_BYTE) && byte_end && !pwr_dn
                  && (byte_no >= BN_W'(2)) && (byte_no < BN_W'(NREGS + 2));
        wr_idx  = IDX_W'(byte_no - BN_W'(2));
        wr_data = rx_sh;
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
    parameter int NREGS = 7,
    parameter int DW    = 8,
    localparam int IDX_W = $clog2(NREGS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                pwr_dn,
    output logic                sda_pull,
    output logic [NREGS*DW-1:0] regs_o,
    output logic                ss_narrow,
    output logic [2:0]          freq_code,
    output logic                freq_from_reg,
    output logic                ss_down,
    output logic                ss_on,
    output logic                hiz_all
);
    logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DW-1:0]    wr_data, rd_data;

    i2c_line_sync #(.SYNC_N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .mask(pwr_dn),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .ev_start(ev_start), .ev_stop(ev_stop)
    );

    cfg_bus_fsm #(.NREGS(NREGS), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sda_lvl(sda_lvl),
        .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
        .rd_data(rd_data), .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx)
    );

    cfg_reg_bank #(.NREGS(NREGS), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .regs_flat(regs_o)
    );

    // R10: register 0 field decode
    assign ss_narrow     = regs_o[7];
    assign freq_code     = regs_o[6:4];
    assign freq_from_reg = regs_o[3];
    assign ss_down       = regs_o[2];
    assign ss_on         = regs_o[1];
    assign hiz_all       = regs_o[0];
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
    parameter int NREGS = 7,
    parameter int DW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_dn,
    input logic                sda_pull,
    input logic                scl_lvl,
    input logic [NREGS*DW-1:0] regs_o
);
    logic [NREGS*DW-1:0] prev_q, dflt;
    int                  chg_cnt;

    always_ff @(posedge clk) prev_q <= regs_o;

    always_comb begin
        chg_cnt = 0;
        dflt    = '1;
        dflt[DW-1:0] = '0;
        for (int i = 0; i < NREGS; i++)
            if (regs_o[i*DW +: DW] != prev_q[i*DW +: DW]) chg_cnt++;
    end

    a_r1_reset_contents: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_o == dflt));

    a_r2_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);

    a_r2_release_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> (!scl_lvl || $past(pwr_dn)));

    a_r4_one_reg_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        chg_cnt <= 1);

    a_r9_no_pull_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !sda_pull);

    a_r9_hold_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> $stable(regs_o));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NREGS(NREGS), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sda_pull(sda_pull),
    .scl_lvl(scl_lvl), .regs_o(regs_o)
);

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;
    localparam int NREGS = 7;
    localparam int DW    = 8;
    localparam int Q     = 8;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, pwr_dn = 1'b0;
    logic sda_pull, sda_line;
    logic [NREGS*DW-1:0] regs_o;
    logic ss_narrow, freq_from_reg, ss_down, ss_on, hiz_all;
    logic [2:0] freq_code;

    always #2.5 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    cfg_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .pwr_dn(pwr_dn),
        .sda_pull(sda_pull), .regs_o(regs_o), .ss_narrow(ss_narrow), .freq_code(freq_code),
        .freq_from_reg(freq_from_reg), .ss_down(ss_down), .ss_on(ss_on), .hiz_all(hiz_all)
    );

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];
    int   got_q[$];
    int   n_vec = 0, n_bad = 0;
    logic [7:0] model [NREGS];
    logic [7:0] wbuf [16];
    exp_t e_m;
    int   g_m;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares read-back bytes against scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0 && got_q.size() > 0) begin
            e_m = exp_q.pop_front();
            g_m = got_q.pop_front();
            chk(e_m.req, g_m, e_m.val);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; m_scl = 1; tick(Q);
        m_sda = 0; tick(Q);
        m_scl = 0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(Q);
        m_scl = 1; tick(Q);
        m_sda = 1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1; tick(2 * Q);
        m_scl = 0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1; tick(Q);
        m_scl = 1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack_n);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(nack);
    endtask

    // full write: address D2, two dummy bytes, n data bytes from wbuf
    task automatic wr_txn(input string req, input int n);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk({req, " addr ack"}, a, 0);
        send_byte(8'h5C, a); chk("R3 cmd ack", a, 0);
        send_byte(8'hE7, a); chk("R3 count ack", a, 0);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk({req, " data ack"}, a, 0);
            if (k < NREGS) model[k] = wbuf[k];
        end
        bus_stop();
        tick(4);
    endtask

    task automatic rd_txn(input string req, input int n);
        logic a, b;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, a); chk("R2 read addr ack", a, 0);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back('{req, (k < NREGS) ? int'(model[k]) : 'hFF});
            recv_byte(v, k == n - 1);
            got_q.push_back(int'(v));
        end
        tick(4);
        chk("R8 released after nack", sda_pull, 0);
        recv_bit(b); chk("R8 no further bits", b, 1);
        bus_stop();
        tick(4);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NREGS; i++) chk(req, regs_o[i*DW +: DW], model[i]);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < NREGS; i++) model[i] = (i == 0) ? 8'h00 : 8'hFF;
        tick(5); rst_n = 1; tick(5);

        // R1 reset state
        chk_regs("R1 reset value");
        chk("R1 sda idle", sda_pull, 0);

        // R3: dummies only
        wr_txn("R3", 0);
        chk_regs("R3 dummies discarded");

        // R4: three data bytes
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        wr_txn("R4", 3);
        chk_regs("R4 ascending fill");

        // R7 / R8: read three back, NACK last
        rd_txn("R7 readback", 3);

        // R2: foreign address not acked
        bus_start();
        send_byte(8'hA0, a); chk("R2 foreign addr nack", a, 1);
        bus_stop(); tick(4);
        chk_regs("R2 foreign addr no change");

        // R10 field decode
        wbuf[0] = 8'hDA;
        wr_txn("R10", 1);
        chk("R10 ss_narrow", ss_narrow, 1);
        chk("R10 freq_code", freq_code, 5);
        chk("R10 freq_from_reg", freq_from_reg, 1);
        chk("R10 ss_down", ss_down, 0);
        chk("R10 ss_on", ss_on, 1);
        chk("R10 hiz_all", hiz_all, 0);

        // R5: one complete byte then 4 bits then STOP
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h11, a); chk("R5 data ack", a, 0);
        model[0] = 8'h11;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop(); tick(4);
        chk_regs("R5 partial byte dropped");

        // R6 / R11: nine data bytes, overflow dropped
        for (int k = 0; k < 9; k++) wbuf[k] = 8'h30 + 8'(k * 7);
        wbuf[6] = 8'h3C;
        wr_txn("R6", 9);
        chk_regs("R6 overflow dropped");
        rd_txn("R11 full readback", NREGS + 1);

        // R9: power-down ignores bus, keeps contents
        pwr_dn = 1; tick(4);
        bus_start();
        send_byte(8'hD2, a); chk("R9 no ack in power-down", a, 1);
        send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h99, a);
        bus_stop(); tick(4);
        chk_regs("R9 regs held in power-down");
        pwr_dn = 0; tick(4);
        chk_regs("R9 regs retained after power-down");
        rd_txn("R9 readback after power-down", 2);

        tick(20);
        chk("R7 scoreboard drained", exp_q.size() + got_q.size(), 0);
        summary();
        $finish;
    end
endmodule